// File: doc/BRIEF.md
# Tri-Level SAR Plate Switching Sequencer

This block steps a 10-bit differential successive-approximation converter through its repeating cycle. Each side of the capacitor array (positive and negative) has two banks of eight binary-weighted capacitors: an upper bank, which holds the split most significant weight, and a lower bank. A connection switch joins the two banks of a side. Every bottom plate sits at one of three levels (ground, mid-supply common mode, full reference). The sequencer drives a 2-bit level code for every plate, the connection and sampling switch enables, and a comparator strobe. It builds the output code from the comparator's answers.

The cycle has four phases. First the connection switches open while the plates hold their levels. Next the plates are restored. Then the banks sample separately. Last the banks are connected and the conversion runs. The first decision needs no plate motion. The first two decisions move whole banks, and the later decisions each lower a single lower-bank capacitor on the side that compared higher. A plate level only ever steps downward while the banks are connected. The only upward moves happen in the restore cycle, after the connection switches have opened.

Top module: `tri_sar_seq`

## Requirements
- R1: While `rst_n` is low, `link_en`, `samp_en`, `cmp_strobe` and `done` are 0 and `code` is 0. Every upper-bank plate holds code 2'b10 (reference) and every lower-bank plate holds 2'b01 (common mode). 2'b00 is ground. Plate i sits in field [2i+1:2i]. Capacitor 0 is the largest weight (64), capacitors 1 to 6 halve in turn, and capacitor 7 is a second unit capacitor.
- R2: The sampling phase lasts `SMP_CYC` cycles. During it `samp_en` is 1, `link_en` and `cmp_strobe` are 0, and all plates stay at their restored levels.
- R3: The conversion phase lasts `CAPS`+2 consecutive cycles. During it `link_en` and `cmp_strobe` are 1, and during the first of these cycles the plates still hold their sampling levels.
- R4: `cmp_dec`=1 means the positive input is higher. The first decision, latched at the end of the first strobe cycle, lowers both banks of the higher side by one level: the upper bank goes to 2'b01 and the lower bank goes to 2'b00. The other side is unchanged.
- R5: The second decision lowers the upper bank of the side found higher by one level. That is positive 2'b01→2'b00 after a positive first move, negative 2'b10→2'b01 after a positive first move, positive 2'b10→2'b01 after a negative first move, and negative 2'b01→2'b00 after a negative first move.
- R6: Decision k, for k from 3 to `CAPS`+1, lowers lower-bank capacitor k-3 of the higher side by one level if it is above ground, and otherwise leaves it. The last decision changes nothing, and capacitor `CAPS`-1 never moves.
- R7: Decision k is placed in `code` bit `CAPS`+2-k, so the result is built MSB first. For an ideal comparator this gives the plain binary quantisation of the differential input, offset by half scale.
- R8: After the last decision comes one cycle with `done` high, `link_en` and `samp_en` low and plates unchanged, and `code` is valid in that cycle. `code` keeps that value until the next `done`.
- R9: The cycle after `done` restores all plates to their R1 levels with both enables low. Sampling follows.
- R10: Code 2'b11 never appears on any plate. A plate level rises only in a cycle where `link_en` is low and was also low in the previous cycle.
- R11: `link_en` and `samp_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_dec | input | 1 | Comparator answer, 1 when the positive side is higher |
| cmp_strobe | output | 1 | Fires the comparator, one decision per cycle |
| samp_en | output | 1 | Closes the per-bank sampling switches on both sides |
| link_en | output | 1 | Closes the upper-to-lower bank connection switches |
| pos_msb_lvl | output | 2*CAPS | Level codes, positive upper bank |
| pos_lsb_lvl | output | 2*CAPS | Level codes, positive lower bank |
| neg_msb_lvl | output | 2*CAPS | Level codes, negative upper bank |
| neg_lsb_lvl | output | 2*CAPS | Level codes, negative lower bank |
| code | output | CAPS+2 | Conversion result |
| done | output | 1 | One-cycle pulse marking a valid `code` |

## Verification
The assertions check four things on every cycle. No plate carries the illegal code. Levels rise only while both bank links are open. The two switch enables are never high together. Around each `done` pulse, the plates hold, the code stays fixed, and a full restore follows. Only the bench's sweep can show that the right bank or capacitor moves for each pattern of decisions, through all four second-decision cases. It also shows that every one of the 1024 codes, across sub-step input offsets, comes out as the ideal quantisation.

// File: rtl/tri_sar_seq.sv
module tri_sar_seq #(
  parameter int CAPS    = 8,
  parameter int SMP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_dec,
  output logic              cmp_strobe,
  output logic              samp_en,
  output logic              link_en,
  output logic [2*CAPS-1:0] pos_msb_lvl,
  output logic [2*CAPS-1:0] pos_lsb_lvl,
  output logic [2*CAPS-1:0] neg_msb_lvl,
  output logic [2*CAPS-1:0] neg_lsb_lvl,
  output logic [CAPS+1:0]   code,
  output logic              done
);
  localparam int NBITS = CAPS + 2;
  localparam int CMAX  = (NBITS > SMP_CYC) ? NBITS : SMP_CYC;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [1:0] LV_GND = 2'b00;
  localparam logic [1:0] LV_CM  = 2'b01;
  localparam logic [1:0] LV_REF = 2'b10;
  localparam logic [2*CAPS-1:0] UP_INIT = {CAPS{LV_REF}};
  localparam logic [2*CAPS-1:0] LO_INIT = {CAPS{LV_CM}};

  typedef enum logic [1:0] {ST_CLEAR, ST_SAMPLE, ST_CONV, ST_OPEN} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  int                k;
  logic [NBITS-1:0]  wrk, wrk_n;
  logic [2*CAPS-1:0] pm, pl, nm, nl;

  function automatic logic [1:0] lower(input logic [1:0] v);
    return (v == LV_REF) ? LV_CM : LV_GND;
  endfunction

  function automatic logic [2*CAPS-1:0] lower_bank(input logic [2*CAPS-1:0] b);
    logic [2*CAPS-1:0] r;
    for (int i = 0; i < CAPS; i++) r[2*i +: 2] = lower(b[2*i +: 2]);
    return r;
  endfunction

  function automatic logic [2*CAPS-1:0] lower_cap(input logic [2*CAPS-1:0] b, input int idx);
    logic [2*CAPS-1:0] r;
    r = b;
    r[2*idx +: 2] = lower(b[2*idx +: 2]);
    return r;
  endfunction

  assign k = int'(cnt);

  always_comb begin
    wrk_n = wrk;
    if (k < NBITS) wrk_n[NBITS-1-k] = cmp_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_CLEAR;
      cnt  <= '0;
      wrk  <= '0;
      code <= '0;
      pm   <= UP_INIT;
      nm   <= UP_INIT;
      pl   <= LO_INIT;
      nl   <= LO_INIT;
    end else begin
      case (st)
        ST_CLEAR: begin
          st  <= ST_SAMPLE;
          cnt <= '0;
        end
        ST_SAMPLE: begin
          if (k == SMP_CYC - 1) begin
            st  <= ST_CONV;
            cnt <= '0;
            wrk <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_CONV: begin
          wrk <= wrk_n;
          if (k == 0) begin
            if (cmp_dec) begin
              pm <= lower_bank(pm);
              pl <= lower_bank(pl);
            end else begin
              nm <= lower_bank(nm);
              nl <= lower_bank(nl);
            end
          end else if (k == 1) begin
            if (cmp_dec) pm <= lower_bank(pm);
            else         nm <= lower_bank(nm);
          end else if (k <= NBITS - 2) begin
            if (cmp_dec) pl <= lower_cap(pl, k - 2);
            else         nl <= lower_cap(nl, k - 2);
          end
          if (k == NBITS - 1) begin
            st   <= ST_OPEN;
            code <= wrk_n;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_OPEN: begin
          st <= ST_CLEAR;
          pm <= UP_INIT;
          nm <= UP_INIT;
          pl <= LO_INIT;
          nl <= LO_INIT;
        end
        default: st <= ST_CLEAR;
      endcase
    end
  end

  assign cmp_strobe  = (st == ST_CONV);
  assign link_en     = (st == ST_CONV);
  assign samp_en     = (st == ST_SAMPLE);
  assign done        = (st == ST_OPEN);
  assign pos_msb_lvl = pm;
  assign pos_lsb_lvl = pl;
  assign neg_msb_lvl = nm;
  assign neg_lsb_lvl = nl;
endmodule

// File: rtl/tri_sar_seq_chk.sv
module tri_sar_seq_chk #(
  parameter int CAPS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_strobe,
  input logic              samp_en,
  input logic              link_en,
  input logic [2*CAPS-1:0] pos_msb_lvl,
  input logic [2*CAPS-1:0] pos_lsb_lvl,
  input logic [2*CAPS-1:0] neg_msb_lvl,
  input logic [2*CAPS-1:0] neg_lsb_lvl,
  input logic [CAPS+1:0]   code,
  input logic              done
);
  localparam int W = 2 * CAPS;

  logic [4*W-1:0] all_lv, prev_lv;
  logic           prev_ok, illegal, rose;

  assign all_lv = {pos_msb_lvl, pos_lsb_lvl, neg_msb_lvl, neg_lsb_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ok <= 1'b0;
      prev_lv <= '0;
    end else begin
      prev_ok <= 1'b1;
      prev_lv <= all_lv;
    end
  end

  always_comb begin
    illegal = 1'b0;
    rose    = 1'b0;
    for (int i = 0; i < 4 * CAPS; i++) begin
      if (all_lv[2*i +: 2] == 2'b11) illegal = 1'b1;
      if (prev_ok && (all_lv[2*i +: 2] > prev_lv[2*i +: 2])) rose = 1'b1;
    end
  end

  a_r10_no_illegal_level: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal);

  a_r10_rise_only_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
    rose |-> (!link_en && !$past(link_en)));

  a_r11_link_samp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_en && samp_en));

  a_r3_strobe_while_linked: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> (link_en && !samp_en));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_switches_open: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!link_en && !samp_en));

  a_r6_final_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prev_ok && all_lv == prev_lv));

  a_r9_restore_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pos_msb_lvl == {CAPS{2'b10}} && neg_msb_lvl == {CAPS{2'b10}} &&
              pos_lsb_lvl == {CAPS{2'b01}} && neg_lsb_lvl == {CAPS{2'b01}} &&
              !link_en && !samp_en));

  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && !done) |-> $stable(code));
endmodule

bind tri_sar_seq tri_sar_seq_chk #(.CAPS(CAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe), .samp_en(samp_en),
  .link_en(link_en), .pos_msb_lvl(pos_msb_lvl), .pos_lsb_lvl(pos_lsb_lvl),
  .neg_msb_lvl(neg_msb_lvl), .neg_lsb_lvl(neg_lsb_lvl), .code(code), .done(done)
);

// File: tb/tri_sar_seq_bench.sv
module tri_sar_seq_bench;
  localparam int CAPS = 8;
  localparam int SMP  = 2;
  localparam int NB   = CAPS + 2;
  localparam int W    = 2 * CAPS;
  localparam int HALF = 1 << (NB - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_dec = 1'b0;
  logic cmp_strobe, samp_en, link_en, done;
  logic [W-1:0] pos_msb_lvl, pos_lsb_lvl, neg_msb_lvl, neg_lsb_lvl;
  logic [NB-1:0] code;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic [W-1:0] e_pm, e_pl, e_nm, e_nl;
  logic [NB-1:0] prev_code;
  bit first_side;

  tri_sar_seq #(.CAPS(CAPS), .SMP_CYC(SMP)) u_tri_sar_seq (
    .clk(clk), .rst_n(rst_n), .cmp_dec(cmp_dec), .cmp_strobe(cmp_strobe),
    .samp_en(samp_en), .link_en(link_en), .pos_msb_lvl(pos_msb_lvl),
    .pos_lsb_lvl(pos_lsb_lvl), .neg_msb_lvl(neg_msb_lvl), .neg_lsb_lvl(neg_lsb_lvl),
    .code(code), .done(done)
  );

  always #2 clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_plates(input string req);
    chk(pos_msb_lvl == e_pm, req, "pos upper bank", pos_msb_lvl, e_pm);
    chk(pos_lsb_lvl == e_pl, req, "pos lower bank", pos_lsb_lvl, e_pl);
    chk(neg_msb_lvl == e_nm, req, "neg upper bank", neg_msb_lvl, e_nm);
    chk(neg_lsb_lvl == e_nl, req, "neg lower bank", neg_lsb_lvl, e_nl);
  endtask

  task automatic chk_every_cycle();
    bit bad;
    logic [4*W-1:0] v;
    bad = 1'b0;
    v = {pos_msb_lvl, pos_lsb_lvl, neg_msb_lvl, neg_lsb_lvl};
    for (int i = 0; i < 4 * CAPS; i++) if (v[2*i +: 2] == 2'b11) bad = 1'b1;
    chk(!bad, "R10", "illegal level code", bad, 0);
    chk(!(link_en && samp_en), "R11", "link and sample together", {link_en, samp_en}, 0);
  endtask

  task automatic set_init();
    e_pm = {CAPS{2'b10}};
    e_nm = {CAPS{2'b10}};
    e_pl = {CAPS{2'b01}};
    e_nl = {CAPS{2'b01}};
  endtask

  task automatic model(input int k, input bit d);
    if (k == 0) begin
      first_side = d;
      if (d) begin e_pm = {CAPS{2'b01}}; e_pl = {CAPS{2'b00}}; end
      else   begin e_nm = {CAPS{2'b01}}; e_nl = {CAPS{2'b00}}; end
    end else if (k == 1) begin
      case ({first_side, d})
        2'b11: e_pm = {CAPS{2'b00}};
        2'b10: e_nm = {CAPS{2'b01}};
        2'b01: e_pm = {CAPS{2'b01}};
        default: e_nm = {CAPS{2'b00}};
      endcase
    end else if (k <= NB - 2) begin
      if (d) begin if (e_pl[2*(k-2) +: 2] == 2'b01) e_pl[2*(k-2) +: 2] = 2'b00; end
      else   begin if (e_nl[2*(k-2) +: 2] == 2'b01) e_nl[2*(k-2) +: 2] = 2'b00; end
    end
  endtask

  task automatic conv(input int v);
    int part, trial, expc;
    bit d;
    expc = (v + 4 * HALF) / 4;
    set_init();
    chk_every_cycle();
    chk(!link_en && !samp_en && !cmp_strobe && !done, "R9", "restore phase switches",
        {link_en, samp_en, cmp_strobe, done}, 0);
    chk_plates("R9");
    chk(code == prev_code, "R8", "code held", code, prev_code);
    for (int s = 0; s < SMP; s++) begin
      @(negedge clk);
      chk_every_cycle();
      chk(samp_en && !link_en && !cmp_strobe, "R2", "sample phase switches",
          {samp_en, link_en, cmp_strobe}, 3'b100);
      chk_plates("R2");
    end
    part = 0;
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      chk_every_cycle();
      chk(cmp_strobe && link_en && !samp_en && !done, "R3", "conversion strobe",
          {cmp_strobe, link_en, samp_en, done}, 4'b1100);
      if (k == 0)      chk_plates("R3");
      else if (k == 1) chk_plates("R4");
      else if (k == 2) chk_plates("R5");
      else             chk_plates("R6");
      trial = part | (1 << (NB - 1 - k));
      d = (v >= 4 * (trial - HALF));
      cmp_dec = d;
      if (d) part = trial;
      model(k, d);
    end
    @(negedge clk);
    chk_every_cycle();
    chk(done && !link_en && !samp_en, "R8", "done cycle", {done, link_en, samp_en}, 3'b100);
    chk_plates("R6");
    chk(code == NB'(expc), "R7", "result code", code, expc);
    prev_code = NB'(expc);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    set_init();
    chk(!link_en && !samp_en && !cmp_strobe && !done, "R1", "reset switches",
        {link_en, samp_en, cmp_strobe, done}, 0);
    chk_plates("R1");
    chk(code == '0, "R1", "reset code", code, 0);
    prev_code = '0;
    rst_n = 1'b1;
    for (int c = 0; c < 2 * HALF; c++) conv(4 * (c - HALF) + (c % 4));
    conv(-4 * HALF);
    conv(4 * HALF - 1);
    report();
  end
endmodule